// File: doc/BRIEF.md
# Debug-Link Flash Programming Sequencer

This block runs whole flash operations on a target chip over a two-wire debug link. It does not drive the wires itself. It asks a separate frame master for one frame at a time: an address-register write, an address-register read, a data-register write or a data-register read. It then reads each frame's reply. From those frames it builds four operations: unlocking programming mode, erasing the whole device, reading a block and writing a block.

Every flash command uses the same steps. The sequencer selects the target's flash data register, sends the command byte and waits for the target's input-busy flag to clear. It then waits for the output-ready flag and checks that the returned status byte is the OK code. Block transfers then send a two-byte offset and a byte count, and each of those bytes gets its own handshake. A second status check follows, and then the data moves. Read bytes leave on a valid/ready output stream, and write bytes arrive on a valid/ready input stream. Each operation ends with a one-cycle done pulse, a success flag and an error code.

A host starts an operation by pulsing `op_start` with an operation code, an offset and a requested count. It waits for `done` before starting another operation.

Top module: `dlink_flash_seq`

## Requirements
- R1: Erase, read and write (op_code 1, 2, 3) started before a completed unlock (op_code 0) issue no frame and end with err = 1 (locked). Error codes are: 0 none, 1 locked, 2 range, 3 bad status, 4 poll exhausted, 5 frame timeout.
- R2: Unlock issues the following frames and then finishes successfully exactly UNLOCK_WAIT+1 cycles after the acknowledge of its last frame. The frames are: an address write of 0x02, a data write of 0x02 and a data write of 0x01, with no polling between them. Frame kinds are encoded as 0 address write, 1 address read, 2 data write and 3 data read.
- R3: A read or write is rejected with err = 2 and no frames when the offset is at or beyond FLASH_BYTES. Otherwise the transfer length is the smallest of the requested count, MAX_XFER and FLASH_BYTES minus the offset. A length of zero completes successfully with no frames.
- R4: Erase issues the following frames in this order: an address write of 0xB4, a data write of 0x03, an input-busy poll, an output-ready poll and a data read of the status. If the status is OK, it then writes the key bytes 0xDE, 0xAD and 0xA5, each followed by an input-busy poll, and ends with an output-ready poll.
- R5: A block read sends the prefix described below. It then performs output-ready poll plus data read once per byte, and presents each byte on rd_data in order, held while rd_valid is high and rd_ready is low. The prefix is: an address write of 0xB4, a data write of 0x06, an input-busy poll, an output-ready poll and a status read. Then come the offset high byte, the offset low byte and the length, each written and each followed by an input-busy poll. Then come an output-ready poll and a second status read.
- R6: A block write sends the same prefix as R5 but with command 0x07. It then takes each byte from the write stream, writes it and follows it with an input-busy poll. It ends with one output-ready poll.
- R7: Any status byte other than 0x0D ends the operation with err = 3 right after that status read.
- R8: An input-busy poll repeats address reads while bit 1 of the reply is set. After IB_TRIES busy replies it ends with err = 4.
- R9: An output-ready poll repeats address reads while bit 0 of the reply is clear. After OR_TRIES not-ready replies it ends with err = 4.
- R10: A frame acknowledged with fr_tmo ends the operation at once with err = 5, and no further frame is issued.
- R11: A pulse on tgt_reset cancels a completed unlock, so the next erase, read or write fails with err = 1.
- R12: After reset, done, ok and err are 0. done is a single-cycle pulse with no frame request in that cycle, and ok is 1 exactly when the err that goes with it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tgt_reset | input | 1 | Pulse: the target was reset, so programming mode is lost |
| op_start | input | 1 | Starts an operation when the block is idle |
| op_code | input | 2 | 0 unlock, 1 erase, 2 block read, 3 block write |
| op_offset | input | 16 | Flash start offset |
| op_count | input | 8 | Requested byte count |
| done | output | 1 | One-cycle end-of-operation pulse |
| ok | output | 1 | Last operation succeeded |
| err | output | 3 | Last operation's error code |
| fr_req | output | 1 | Frame request, held until acknowledged |
| fr_kind | output | 2 | Frame kind: 0 AW, 1 AR, 2 DW, 3 DR |
| fr_wdata | output | 8 | Byte sent by a write frame |
| fr_ack | input | 1 | Frame finished (one cycle) |
| fr_tmo | input | 1 | With fr_ack: the frame timed out |
| fr_rdata | input | 8 | Byte returned by a read frame |
| wr_valid | input | 1 | Write-stream byte available |
| wr_data | input | 8 | Write-stream byte |
| wr_ready | output | 1 | Sequencer takes a write byte |
| rd_valid | output | 1 | Read-stream byte available |
| rd_data | output | 8 | Read-stream byte |
| rd_ready | input | 1 | Consumer takes the read byte |

## Verification
The bench builds the block with FLASH_BYTES = 1024. With that size, offsets near the end of flash clip a transfer to a few bytes, while the offset high byte is still non-zero. OR_TRIES = 40 and UNLOCK_WAIT = 50 make output-ready exhaustion and the exact unlock delay measurable in a short run. IB_TRIES keeps its default of 20, and a target model that stays busy longer than that reaches the input-busy give-up. MAX_XFER keeps 128, so requested counts up to 200 show the per-transfer cap.

// File: rtl/dlink_flash_seq.sv
module dlink_flash_seq #(
  parameter int FLASH_BYTES = 16384,
  parameter int MAX_XFER    = 128,
  parameter int IB_TRIES    = 20,
  parameter int OR_TRIES    = 10000,
  parameter int UNLOCK_WAIT = 5000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tgt_reset,
  input  logic       op_start,
  input  logic [1:0] op_code,
  input  logic [15:0] op_offset,
  input  logic [7:0] op_count,
  output logic       done,
  output logic       ok,
  output logic [2:0] err,
  output logic       fr_req,
  output logic [1:0] fr_kind,
  output logic [7:0] fr_wdata,
  input  logic       fr_ack,
  input  logic       fr_tmo,
  input  logic [7:0] fr_rdata,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  output logic       wr_ready,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  input  logic       rd_ready
);
  localparam int CMAX = (OR_TRIES > UNLOCK_WAIT) ? ((OR_TRIES > IB_TRIES) ? OR_TRIES : IB_TRIES)
                                                 : ((UNLOCK_WAIT > IB_TRIES) ? UNLOCK_WAIT : IB_TRIES);
  localparam int CW = $clog2(CMAX + 1);
  localparam logic [1:0] OP_UNL = 2'd0, OP_ERS = 2'd1, OP_RD = 2'd2;
  localparam logic [1:0] K_AW = 2'd0, K_AR = 2'd1, K_DW = 2'd2, K_DR = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_SEL, S_CMD, S_IB, S_OR, S_STAT, S_KEY, S_ADDH,
    S_ADDL, S_CNT, S_RDB, S_PUSH, S_PULL, S_WRB, S_STEP, S_WAIT
  } st_t;

  st_t st, ib_ret, or_ret;
  logic [1:0] op;
  logic [15:0] off;
  logic [7:0] n, idx, byte_q, key;
  logic [CW-1:0] cnt;
  logic second, unlocked;
  int remain_i, clip_i;

  always_comb begin
    remain_i = FLASH_BYTES - int'(op_offset);
    clip_i = int'(op_count);
    if (clip_i > MAX_XFER) clip_i = MAX_XFER;
    if (clip_i > remain_i) clip_i = remain_i;
    if (clip_i < 0) clip_i = 0;
  end

  always_comb begin
    if (op == OP_UNL) key = idx[0] ? 8'h01 : 8'h02;
    else if (idx == 8'd0) key = 8'hDE;
    else if (idx == 8'd1) key = 8'hAD;
    else key = 8'hA5;
  end

  assign fr_req = st inside {S_SEL, S_CMD, S_IB, S_OR, S_STAT, S_KEY, S_ADDH, S_ADDL, S_CNT, S_RDB, S_WRB};
  assign wr_ready = (st == S_PULL);
  assign rd_valid = (st == S_PUSH);
  assign rd_data  = byte_q;

  always_comb begin
    fr_kind = K_AW;
    fr_wdata = 8'h00;
    case (st)
      S_SEL:  fr_wdata = (op == OP_UNL) ? 8'h02 : 8'hB4;
      S_CMD:  begin fr_kind = K_DW; fr_wdata = (op == OP_ERS) ? 8'h03 : (op == OP_RD) ? 8'h06 : 8'h07; end
      S_IB, S_OR: fr_kind = K_AR;
      S_STAT, S_RDB: fr_kind = K_DR;
      S_KEY:  begin fr_kind = K_DW; fr_wdata = key; end
      S_ADDH: begin fr_kind = K_DW; fr_wdata = off[15:8]; end
      S_ADDL: begin fr_kind = K_DW; fr_wdata = off[7:0]; end
      S_CNT:  begin fr_kind = K_DW; fr_wdata = n; end
      S_WRB:  begin fr_kind = K_DW; fr_wdata = byte_q; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ib_ret <= S_IDLE; or_ret <= S_IDLE;
      op <= OP_UNL; off <= '0; n <= '0; idx <= '0; byte_q <= '0; cnt <= '0;
      second <= 1'b0; unlocked <= 1'b0; done <= 1'b0; ok <= 1'b0; err <= 3'd0;
    end else begin
      done <= 1'b0;
      if (fr_req && fr_ack && fr_tmo) begin
        done <= 1'b1; ok <= 1'b0; err <= 3'd5; st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (op_start) begin
            op <= op_code; off <= op_offset; n <= 8'(clip_i);
            idx <= '0; cnt <= '0; second <= 1'b0;
            if (op_code == OP_UNL) begin
              unlocked <= 1'b0; st <= S_SEL;
            end else if (!unlocked) begin
              done <= 1'b1; ok <= 1'b0; err <= 3'd1;
            end else if (op_code != OP_ERS && int'(op_offset) >= FLASH_BYTES) begin
              done <= 1'b1; ok <= 1'b0; err <= 3'd2;
            end else if (op_code != OP_ERS && clip_i == 0) begin
              done <= 1'b1; ok <= 1'b1; err <= 3'd0;
            end else st <= S_SEL;
          end
          S_SEL: if (fr_ack) st <= (op == OP_UNL) ? S_KEY : S_CMD;
          S_CMD, S_CNT: if (fr_ack) begin st <= S_IB; ib_ret <= S_OR; or_ret <= S_STAT; end
          S_ADDH: if (fr_ack) begin st <= S_IB; ib_ret <= S_ADDL; end
          S_ADDL: if (fr_ack) begin st <= S_IB; ib_ret <= S_CNT; end
          S_WRB:  if (fr_ack) begin st <= S_IB; ib_ret <= S_STEP; end
          S_IB: if (fr_ack) begin
            if (!fr_rdata[1]) begin st <= ib_ret; cnt <= '0; end
            else if (cnt == CW'(IB_TRIES - 1)) begin done <= 1'b1; ok <= 1'b0; err <= 3'd4; st <= S_IDLE; end
            else cnt <= cnt + 1'b1;
          end
          S_OR: if (fr_ack) begin
            if (fr_rdata[0]) begin
              cnt <= '0;
              if (or_ret == S_IDLE) begin done <= 1'b1; ok <= 1'b1; err <= 3'd0; end
              st <= or_ret;
            end
            else if (cnt == CW'(OR_TRIES - 1)) begin done <= 1'b1; ok <= 1'b0; err <= 3'd4; st <= S_IDLE; end
            else cnt <= cnt + 1'b1;
          end
          S_STAT: if (fr_ack) begin
            if (fr_rdata != 8'h0D) begin done <= 1'b1; ok <= 1'b0; err <= 3'd3; st <= S_IDLE; end
            else if (!second) begin second <= 1'b1; st <= (op == OP_ERS) ? S_KEY : S_ADDH; end
            else if (op == OP_RD) begin st <= S_OR; or_ret <= S_RDB; end
            else st <= S_PULL;
          end
          S_KEY: if (fr_ack) begin
            if (op != OP_UNL) begin st <= S_IB; ib_ret <= S_STEP; end
            else if (idx[0]) begin st <= S_WAIT; cnt <= '0; end
            else idx <= idx + 8'd1;
          end
          S_RDB: if (fr_ack) begin byte_q <= fr_rdata; st <= S_PUSH; end
          S_PUSH: if (rd_ready) begin
            if (idx == n - 8'd1) begin done <= 1'b1; ok <= 1'b1; err <= 3'd0; st <= S_IDLE; end
            else begin idx <= idx + 8'd1; st <= S_OR; end
          end
          S_PULL: if (wr_valid) begin byte_q <= wr_data; st <= S_WRB; end
          S_STEP: begin
            if (idx == ((op == OP_ERS) ? 8'd2 : n - 8'd1)) begin st <= S_OR; or_ret <= S_IDLE; end
            else begin idx <= idx + 8'd1; st <= (op == OP_ERS) ? S_KEY : S_PULL; end
          end
          S_WAIT: begin
            if (cnt == CW'(UNLOCK_WAIT - 1)) begin
              unlocked <= 1'b1; done <= 1'b1; ok <= 1'b1; err <= 3'd0; st <= S_IDLE;
            end else cnt <= cnt + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
      if (tgt_reset) unlocked <= 1'b0;
    end
  end
endmodule

// File: rtl/dlink_flash_seq_chk.sv
module dlink_flash_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       done,
  input logic [2:0] err,
  input logic       fr_req,
  input logic       fr_ack,
  input logic       fr_tmo,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       wr_valid,
  input logic       wr_ready
);
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R12
  done_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !fr_req);
  // R10
  tmo_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_req && fr_ack && fr_tmo) |=> (done && err == 3'd5));
  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  // R6
  wr_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && !wr_valid) |=> wr_ready);
endmodule

bind dlink_flash_seq dlink_flash_seq_chk u_chk (.*);

// File: tb/dlink_flash_seq_tb.sv
`timescale 1ns/1ps
module dlink_flash_seq_tb;
  localparam int FB = 1024, MX = 128, IBT = 20, ORT = 40, UW = 50;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, tgt_reset = 1'b0, op_start = 1'b0;
  logic [1:0] op_code = 2'd0;
  logic [15:0] op_offset = '0;
  logic [7:0] op_count = '0;
  logic done, ok;
  logic [2:0] err;
  logic fr_req;
  logic [1:0] fr_kind;
  logic [7:0] fr_wdata;
  logic fr_ack = 1'b0, fr_tmo = 1'b0;
  logic [7:0] fr_rdata = '0;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic wr_ready, rd_valid;
  logic [7:0] rd_data;
  logic rd_ready = 1'b0;

  dlink_flash_seq #(.FLASH_BYTES(FB), .MAX_XFER(MX), .IB_TRIES(IBT), .OR_TRIES(ORT), .UNLOCK_WAIT(UW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tgt_reset(tgt_reset), .op_start(op_start), .op_code(op_code),
    .op_offset(op_offset), .op_count(op_count), .done(done), .ok(ok), .err(err),
    .fr_req(fr_req), .fr_kind(fr_kind), .fr_wdata(fr_wdata), .fr_ack(fr_ack), .fr_tmo(fr_tmo),
    .fr_rdata(fr_rdata), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready));

  int nvec = 0, nfail = 0, cyc = 0;
  logic [9:0] trace [0:511];
  logic [9:0] exp_tr [0:511];
  logic [7:0] rq [0:299];
  logic [7:0] wbuf [0:299];
  logic [7:0] rbuf [0:299];
  int tr_n, ar_n, fr_n, rq_p, wb_p, rb_n, exp_n, exp_ar;
  int kbusy = 0, tmo_at = -1, last_ack = 0;
  bit or_stuck = 0;
  int ib_left = 0, or_left = 0;
  bit m_busy = 0;
  int m_lat = 0;
  logic [1:0] m_kind;
  logic [7:0] m_data;
  logic [2:0] r_err;
  logic r_ok;
  int r_cyc;

  initial forever begin @(posedge clk); cyc++; end

  task automatic chk(bit c, string r, int act, int exp);
    nvec++;
    if (!c) begin nfail++; $display("FAIL %s actual=%0d expected=%0d", r, act, exp); end
  endtask

  task automatic respond();
    fr_tmo = 1'b0; fr_rdata = 8'h00;
    if (fr_n == tmo_at) fr_tmo = 1'b1;
    else case (m_kind)
      2'd0: begin trace[tr_n] = {2'd0, m_data}; tr_n++; end
      2'd1: begin
        ar_n++;
        fr_rdata = {6'd0, ib_left > 0, !or_stuck && or_left == 0};
        if (ib_left > 0) ib_left--;
        if (or_left > 0) or_left--;
      end
      2'd2: begin trace[tr_n] = {2'd2, m_data}; tr_n++; ib_left = kbusy; or_left = kbusy; end
      default: begin
        fr_rdata = rq[rq_p]; rq_p++;
        trace[tr_n] = {2'd3, fr_rdata}; tr_n++; ib_left = kbusy; or_left = kbusy;
      end
    endcase
    fr_n++;
    last_ack = cyc;
    fr_ack = 1'b1;
  endtask

  initial forever begin
    @(negedge clk);
    if (fr_ack) begin fr_ack = 1'b0; fr_tmo = 1'b0; end
    else if (m_busy) begin
      m_lat--;
      if (m_lat == 0) begin m_busy = 0; respond(); end
    end else if (fr_req) begin
      m_kind = fr_kind; m_data = fr_wdata; m_busy = 1; m_lat = 1 + int'($urandom % 3);
    end
  end

  initial forever begin
    @(negedge clk);
    rd_ready = ($urandom % 4) != 0;
    if (rd_valid && rd_ready) begin rbuf[rb_n] = rd_data; rb_n++; end
    wr_valid = ($urandom % 3) != 0;
    wr_data = wbuf[wb_p];
    if (wr_valid && wr_ready) wb_p++;
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_op(int opc, int off, int cnt);
    bit got = 0;
    tr_n = 0; ar_n = 0; fr_n = 0; rq_p = 0; wb_p = 0; rb_n = 0;
    @(negedge clk);
    op_code = 2'(opc); op_offset = 16'(off); op_count = 8'(cnt); op_start = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
    for (int w = 0; w < 20000; w++) begin
      if (done) begin got = 1; break; end
      @(negedge clk);
    end
    r_err = err; r_ok = ok; r_cyc = cyc;
    chk(got, "R12 watchdog: operation never finished", 0, 1);
    @(negedge clk);
    chk(!done, "R12 done lasts one cycle", int'(done), 0);
    chk(r_ok == (r_err == 3'd0), "R12 ok agrees with err", int'(r_ok), int'(r_err == 3'd0));
    if (!got) do_reset();
  endtask

  task automatic ep(int k, int d);
    exp_tr[exp_n] = {k[1:0], d[7:0]}; exp_n++;
  endtask

  task automatic exp_erase(int k);
    exp_n = 0;
    ep(0, 8'hB4); ep(2, 8'h03); ep(3, 8'h0D); ep(2, 8'hDE); ep(2, 8'hAD); ep(2, 8'hA5);
    exp_ar = 4 * (k + 1) + 2;
  endtask

  task automatic exp_rw(bit wr, int off, int n, int k);
    exp_n = 0;
    ep(0, 8'hB4); ep(2, wr ? 8'h07 : 8'h06); ep(3, 8'h0D);
    ep(2, (off >> 8) & 255); ep(2, off & 255); ep(2, n); ep(3, 8'h0D);
    for (int i = 0; i < n; i++) begin
      if (wr) ep(2, int'(wbuf[i])); else ep(3, int'(rq[2 + i]));
    end
    exp_ar = 4 * (k + 1) + 2 + n * (k + 1) + (wr ? 1 : 0);
  endtask

  task automatic cmp_trace(string r);
    chk(tr_n == exp_n, {r, " frame count"}, tr_n, exp_n);
    chk(ar_n == exp_ar, {r, " poll read count"}, ar_n, exp_ar);
    for (int i = 0; i < exp_n && i < tr_n; i++)
      chk(trace[i] == exp_tr[i], {r, " frame content"}, int'(trace[i]), int'(exp_tr[i]));
  endtask

  function automatic int clip(int off, int cnt);
    int c = cnt;
    if (c > MX) c = MX;
    if (c > FB - off) c = FB - off;
    return c;
  endfunction

  task automatic rw_case(bit wr, int off, int cnt, string r);
    int n = clip(off, cnt);
    kbusy = int'($urandom % 4);
    rq[0] = 8'h0D; rq[1] = 8'h0D;
    for (int i = 0; i < 256; i++) begin rq[2 + i] = 8'($urandom); wbuf[i] = 8'($urandom); end
    run_op(wr ? 3 : 2, off, cnt);
    chk(r_err == 3'd0, {r, " error code"}, int'(r_err), 0);
    if (n == 0) begin
      chk(fr_n == 0, "R3 zero length issues no frame", fr_n, 0);
    end else begin
      exp_rw(wr, off, n, kbusy);
      cmp_trace(r);
      if (!wr) begin
        chk(rb_n == n, "R5 streamed byte count", rb_n, n);
        for (int i = 0; i < n && i < rb_n; i++)
          chk(rbuf[i] == rq[2 + i], "R5 streamed byte value", int'(rbuf[i]), int'(rq[2 + i]));
      end else chk(wb_p == n, "R6 bytes taken from stream", wb_p, n);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 300; i++) begin rq[i] = 8'h0D; wbuf[i] = 8'h00; end
    do_reset();
    @(negedge clk);
    chk(!done && !ok && err == 3'd0 && !fr_req, "R12 reset state", int'({done, ok, err, fr_req}), 0);

    run_op(2, 0, 4);
    chk(r_err == 3'd1, "R1 read before unlock", int'(r_err), 1);
    chk(fr_n == 0, "R1 no frame while locked", fr_n, 0);
    run_op(1, 0, 0);
    chk(r_err == 3'd1, "R1 erase before unlock", int'(r_err), 1);

    kbusy = 0;
    run_op(0, 0, 0);
    chk(r_err == 3'd0, "R2 unlock result", int'(r_err), 0);
    exp_n = 0; ep(0, 8'h02); ep(2, 8'h02); ep(2, 8'h01); exp_ar = 0;
    cmp_trace("R2 unlock");
    chk(r_cyc - last_ack == UW + 1, "R2 unlock wait length", r_cyc - last_ack, UW + 1);

    kbusy = 2; rq[0] = 8'h0D;
    run_op(1, 0, 0);
    chk(r_err == 3'd0, "R4 erase result", int'(r_err), 0);
    exp_erase(2); cmp_trace("R4 erase");

    rw_case(0, 16'h0123, 9, "R5 read");
    rw_case(1, 16'h0301, 7, "R6 write");
    rw_case(0, FB - 5, 50, "R3 read clipped at end");
    rw_case(1, 0, 200, "R3 write clipped to max");
    rw_case(0, 40, 0, "R3 zero count");
    for (int t = 0; t < 10; t++)
      rw_case(t[0], int'($urandom % FB), int'($urandom % 40), t[0] ? "R6 random write" : "R5 random read");

    run_op(2, FB, 4);
    chk(r_err == 3'd2, "R3 offset at end rejected", int'(r_err), 2);
    chk(fr_n == 0, "R3 rejected offset issues no frame", fr_n, 0);
    run_op(3, 16'hFFFF, 1);
    chk(r_err == 3'd2, "R3 large offset rejected", int'(r_err), 2);

    kbusy = 0; rq[0] = 8'h02;
    run_op(1, 0, 0);
    chk(r_err == 3'd3, "R7 first status bad", int'(r_err), 3);
    chk(tr_n == 3, "R7 stop after status read", tr_n, 3);
    rq[0] = 8'h0D; rq[1] = 8'h00;
    run_op(2, 8, 3);
    chk(r_err == 3'd3, "R7 second status bad", int'(r_err), 3);
    chk(tr_n == 7, "R7 stop after second status", tr_n, 7);
    rq[1] = 8'h0D;

    kbusy = 30;
    run_op(1, 0, 0);
    chk(r_err == 3'd4, "R8 input busy exhausted", int'(r_err), 4);
    chk(ar_n == IBT, "R8 busy poll attempts", ar_n, IBT);

    kbusy = 1; or_stuck = 1;
    run_op(1, 0, 0);
    chk(r_err == 3'd4, "R9 output ready exhausted", int'(r_err), 4);
    chk(ar_n == 2 + ORT, "R9 ready poll attempts", ar_n, 2 + ORT);
    or_stuck = 0;

    kbusy = 0; tmo_at = 4;
    run_op(3, 0, 2);
    chk(r_err == 3'd5, "R10 frame timeout", int'(r_err), 5);
    chk(fr_n == 5, "R10 no frame after timeout", fr_n, 5);
    tmo_at = -1;

    @(negedge clk); tgt_reset = 1'b1; @(negedge clk); tgt_reset = 1'b0;
    run_op(2, 0, 2);
    chk(r_err == 3'd1, "R11 target reset relocks", int'(r_err), 1);
    run_op(0, 0, 0);
    chk(r_err == 3'd0, "R11 unlock again", int'(r_err), 0);
    rw_case(0, 100, 3, "R11 read after relock");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule